// File: doc/BRIEF.md
# Dual-Mode Serial Peripheral Slave with Shared Interrupt Pin

This block is a byte-oriented SPI slave for a chip's internal core. The master supplies the serial clock and an active-low select. The block samples the serial clock, the select and the data-in pin into the system clock domain. The core sees one received byte at a time, flagged by a one-cycle strobe. It supplies the next byte to send whenever the block takes it.

A configuration input chooses one of two wirings. In the four-wire wiring, bytes come in on the master-out pin and go out on the slave-out pin. In the three-wire wiring, the master-out pin is shared half-duplex. A separate direction input decides whether the slave drives that pin, and the direction never changes on its own. A second configuration input lets the interrupt request appear on the shared master-out pin whenever select is high. The pin output enables come straight from the select pin, so the pads release or take over the lines at once, without waiting for the synchronizer.

Top module: `spi_dual_slave`

## Requirements
- R1: While ss_ni is high, no byte is assembled and rx_valid_o stays low, whatever sck_i and mosi_i do.
- R2: Data on mosi_i is sampled on each rising sck_i edge, most significant bit first. After the eighth rising edge of a byte, rx_byte_o holds the byte and rx_valid_o is high for exactly one clk_i cycle. rx_byte_o changes only in that cycle.
- R3: The outgoing bit changes on falling sck_i edges, most significant bit first. tx_byte_i is captured when select becomes active and again on the falling edge that follows each completed byte. Each capture gives a one-cycle tx_take_o pulse, so N bytes in one selection give N+1 pulses.
- R4: With three_wire_i=0, miso_oe_o is 1 exactly while ss_ni is low, and mosi_oe_o is 0 while ss_ni is low.
- R5: With three_wire_i=1, miso_oe_o is always 0. While ss_ni is low, mosi_oe_o equals dir_i (1 = slave drives), and mosi_o carries the outgoing bit.
- R6: With three_wire_i=1 and dir_i=1, no rx_valid_o strobe is produced.
- R7: While ss_ni is high, mosi_oe_o equals irq_share_i, and when it is set mosi_o equals irq_i. While ss_ni is low, irq_i never reaches mosi_o.
- R8: Raising ss_ni in the middle of a byte discards the partial bits. The next selection starts a fresh byte at bit 7.
- R9: During and right after reset, rx_valid_o, tx_take_o and rx_byte_o are 0.
- R10: Several bytes can be sent back to back in one selection, each received and each sent correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from master |
| ss_ni | input | 1 | Active-low select from master |
| mosi_i | input | 1 | Value on the master-out pin |
| mosi_o | output | 1 | Slave drive value for the master-out pin |
| mosi_oe_o | output | 1 | Output enable for the master-out pin |
| miso_o | output | 1 | Slave-out data |
| miso_oe_o | output | 1 | Output enable for the slave-out pin |
| three_wire_i | input | 1 | 1 = shared half-duplex data pin |
| dir_i | input | 1 | In three-wire wiring, 1 = slave drives the shared pin |
| irq_share_i | input | 1 | 1 = interrupt on the master-out pin while deselected |
| irq_i | input | 1 | Interrupt request from the core |
| tx_byte_i | input | DW | Next byte to send |
| tx_take_o | output | 1 | tx_byte_i was captured this cycle |
| rx_byte_o | output | DW | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_byte_o |

## Verification
Some properties are checked on every cycle: the pin output enables against select and the wiring mode, the interrupt multiplexing while deselected, the single-cycle receive strobe, and the rule that the received byte is stable between strobes. The following can only be shown by the bench's serial transactions: bit order, which edges sample and which change data, the transmit reload between back-to-back bytes, the suppression of receive while the slave drives, and the dropping of a byte aborted by select.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;
  parameter int unsigned DATA_W      = 8;
  parameter int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic sck;
    logic ss_n;
    logic mosi;
  } spi_pins_t;

  localparam spi_pins_t PINS_IDLE = '{sck: 1'b0, ss_n: 1'b1, mosi: 1'b0};
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          sel_start_i,
  input  logic          sck_rise_i,
  input  logic          sck_fall_i,
  input  logic          din_i,
  input  logic          rx_en_i,
  input  logic [DW-1:0] tx_byte_i,
  output logic [DW-1:0] rx_byte_o,
  output logic          rx_valid_o,
  output logic          tx_bit_o,
  output logic          tx_take_o
);
  localparam int unsigned CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] rx_sh, tx_sh, rx_next;

  assign rx_next  = {rx_sh[DW-2:0], din_i};
  assign tx_bit_o = tx_sh[DW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
      tx_take_o  <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      tx_take_o  <= 1'b0;
      if (!sel_i) begin
        bit_cnt <= '0;  // drop any partial byte
      end else begin
        if (sel_start_i || (sck_fall_i && bit_cnt == '0)) begin
          tx_sh     <= tx_byte_i;
          tx_take_o <= 1'b1;
        end else if (sck_fall_i) begin
          tx_sh <= tx_sh << 1;
        end
        if (sck_rise_i) begin
          rx_sh <= rx_next;
          if (bit_cnt == LAST) begin
            bit_cnt <= '0;
            if (rx_en_i) begin
              rx_byte_o  <= rx_next;
              rx_valid_o <= 1'b1;
            end
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_pad_mux.sv
module spi_pad_mux (
  input  logic ss_ni,
  input  logic three_wire_i,
  input  logic dir_i,
  input  logic irq_share_i,
  input  logic irq_i,
  input  logic tx_bit_i,
  output logic mosi_o,
  output logic mosi_oe_o,
  output logic miso_o,
  output logic miso_oe_o
);
  // raw select pin: pads follow select without synchronizer delay
  always_comb begin
    if (ss_ni) begin
      mosi_oe_o = irq_share_i;
      mosi_o    = irq_i & irq_share_i;
      miso_oe_o = 1'b0;
    end else begin
      mosi_oe_o = three_wire_i & dir_i;
      mosi_o    = tx_bit_i & three_wire_i;
      miso_oe_o = ~three_wire_i;
    end
    miso_o = tx_bit_i & miso_oe_o;
  end
endmodule

// File: rtl/spi_dual_slave.sv
module spi_dual_slave
  import spi_dual_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          ss_ni,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe_o,
  output logic          miso_o,
  output logic          miso_oe_o,
  input  logic          three_wire_i,
  input  logic          dir_i,
  input  logic          irq_share_i,
  input  logic          irq_i,
  input  logic [DW-1:0] tx_byte_i,
  output logic          tx_take_o,
  output logic [DW-1:0] rx_byte_o,
  output logic          rx_valid_o
);
  localparam int unsigned PW = $bits(spi_pins_t);

  spi_pins_t pins_raw, pins_s;
  logic      sck_q, ss_q, tx_bit;
  logic      sck_rise, sck_fall, sel, sel_start;

  assign pins_raw = '{sck: sck_i, ss_n: ss_ni, mosi: mosi_i};

  spi_sync #(.W(PW), .STAGES(STAGES), .RST_VAL(PINS_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      ss_q  <= 1'b1;
    end else begin
      sck_q <= pins_s.sck;
      ss_q  <= pins_s.ss_n;
    end
  end

  assign sck_rise  =  pins_s.sck & ~sck_q;
  assign sck_fall  = ~pins_s.sck &  sck_q;
  assign sel       = ~pins_s.ss_n;
  assign sel_start = ~pins_s.ss_n & ss_q;

  spi_shift #(.DW(DW)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .sel_start_i(sel_start),
    .sck_rise_i (sck_rise),
    .sck_fall_i (sck_fall),
    .din_i      (pins_s.mosi),
    .rx_en_i    (~(three_wire_i & dir_i)),
    .tx_byte_i  (tx_byte_i),
    .rx_byte_o  (rx_byte_o),
    .rx_valid_o (rx_valid_o),
    .tx_bit_o   (tx_bit),
    .tx_take_o  (tx_take_o)
  );

  spi_pad_mux u_pad (
    .ss_ni       (ss_ni),
    .three_wire_i(three_wire_i),
    .dir_i       (dir_i),
    .irq_share_i (irq_share_i),
    .irq_i       (irq_i),
    .tx_bit_i    (tx_bit),
    .mosi_o      (mosi_o),
    .mosi_oe_o   (mosi_oe_o),
    .miso_o      (miso_o),
    .miso_oe_o   (miso_oe_o)
  );
endmodule

// File: rtl/spi_dual_slave_chk.sv
module spi_dual_slave_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ss_ni,
  input logic          three_wire_i,
  input logic          irq_share_i,
  input logic          irq_i,
  input logic          mosi_o,
  input logic          mosi_oe_o,
  input logic          miso_oe_o,
  input logic          rx_valid_o,
  input logic          tx_take_o,
  input logic [DW-1:0] rx_byte_o
);
  // R4
  miso_off_desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_ni |-> !miso_oe_o);
  // R4
  miso_on_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ss_ni && !three_wire_i) |-> (miso_oe_o && !mosi_oe_o));
  // R5
  miso_off_3w_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    three_wire_i |-> !miso_oe_o);
  // R7
  irq_on_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_ni && irq_share_i) |-> (mosi_oe_o && (mosi_o == irq_i)));
  // R7
  irq_off_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_ni && !irq_share_i) |-> !mosi_oe_o);
  // R2
  rx_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  // R2
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |-> $stable(rx_byte_o));
  // R3
  take_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_take_o |=> !tx_take_o);
endmodule

bind spi_dual_slave spi_dual_slave_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ss_ni       (ss_ni),
  .three_wire_i(three_wire_i),
  .irq_share_i (irq_share_i),
  .irq_i       (irq_i),
  .mosi_o      (mosi_o),
  .mosi_oe_o   (mosi_oe_o),
  .miso_oe_o   (miso_oe_o),
  .rx_valid_o  (rx_valid_o),
  .tx_take_o   (tx_take_o),
  .rx_byte_o   (rx_byte_o)
);

// File: tb/tb_spi_dual_slave.sv
`timescale 1ns/1ps
module tb_spi_dual_slave;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic sck = 1'b0, ss_n = 1'b1, mst_mosi = 1'b0;
  logic three_wire = 1'b0, dir = 1'b0, irq_share = 1'b0, irq = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic mosi_o, mosi_oe, miso_o, miso_oe, tx_take, rx_valid;
  logic [7:0] rx_byte;
  wire  mosi_pin = mosi_oe ? mosi_o : mst_mosi;

  int n_chk = 0, n_fail = 0, rx_cnt = 0, take_cnt = 0;
  logic [7:0] rx_last = 8'h00;
  bit done = 0;

  always #5 clk = ~clk;

  spi_dual_slave dut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .ss_ni(ss_n), .mosi_i(mosi_pin),
    .mosi_o(mosi_o), .mosi_oe_o(mosi_oe), .miso_o(miso_o), .miso_oe_o(miso_oe),
    .three_wire_i(three_wire), .dir_i(dir), .irq_share_i(irq_share), .irq_i(irq),
    .tx_byte_i(tx_byte), .tx_take_o(tx_take), .rx_byte_o(rx_byte), .rx_valid_o(rx_valid)
  );

  always @(negedge clk) begin
    if (rx_valid) begin rx_cnt++; rx_last = rx_byte; end
    if (tx_take) take_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] m, output logic [7:0] seen, output bit oe_ok);
    oe_ok = 1;
    for (int i = 7; i >= 0; i--) begin
      mst_mosi = m[i];
      wclk(6);
      seen[i] = three_wire ? mosi_o : miso_o;
      if (miso_oe !== !three_wire || mosi_oe !== (three_wire & dir)) oe_ok = 0;
      sck = 1'b1; wclk(6);
      sck = 1'b0; wclk(6);
    end
  endtask

  typedef struct packed {
    logic       tw;
    logic       dr;
    logic [7:0] m;
    logic [7:0] t;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 1'b0, 8'hA5, 8'h3C},
    '{1'b0, 1'b0, 8'h01, 8'h80},
    '{1'b1, 1'b0, 8'hC3, 8'h00},
    '{1'b1, 1'b1, 8'h00, 8'h96},
    '{1'b1, 1'b1, 8'hFF, 8'h5A}
  };

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] seen;
    bit oe_ok;
    int rc0, tk0;

    wclk(3);
    // R9 reset state
    chk(rx_valid == 0 && tx_take == 0 && rx_byte == 0, "R9 reset outputs", {rx_valid, tx_take, rx_byte}, 0);
    chk(mosi_oe == 0 && miso_oe == 0, "R9 pads idle", {mosi_oe, miso_oe}, 0);
    rst_ni = 1'b1;
    wclk(4);
    chk(rx_byte == 0 && rx_cnt == 0, "R9 after reset", rx_byte, 0);

    // R1 clocking while deselected
    for (int i = 0; i < 10; i++) begin
      mst_mosi = i[0]; sck = 1'b1; wclk(5); sck = 1'b0; wclk(5);
    end
    chk(rx_cnt == 0, "R1 no rx while deselected", rx_cnt, 0);

    // vector table: R2 R3 R4 R5 R6
    foreach (VECS[k]) begin
      three_wire = VECS[k].tw; dir = VECS[k].dr; tx_byte = VECS[k].t;
      rc0 = rx_cnt; tk0 = take_cnt;
      wclk(2);
      ss_n = 1'b0; wclk(8);
      spi_byte(VECS[k].m, seen, oe_ok);
      wclk(4);
      ss_n = 1'b1; wclk(6);
      chk(oe_ok, "R4/R5 output enables", oe_ok, 1);
      if (VECS[k].tw && VECS[k].dr) begin
        chk(seen == VECS[k].t, "R5 shared pin tx", seen, VECS[k].t);
        chk(rx_cnt == rc0, "R6 no rx while driving", rx_cnt - rc0, 0);
      end else begin
        chk(rx_cnt == rc0 + 1, "R2 one strobe", rx_cnt - rc0, 1);
        chk(rx_last == VECS[k].m, "R2 rx byte", rx_last, VECS[k].m);
        if (!VECS[k].tw) chk(seen == VECS[k].t, "R3 miso tx", seen, VECS[k].t);
      end
      chk(take_cnt == tk0 + 2, "R3 take count", take_cnt - tk0, 2);
    end

    // R10 back to back bytes
    three_wire = 1'b0; dir = 1'b0; tx_byte = 8'hE1;
    rc0 = rx_cnt; tk0 = take_cnt;
    ss_n = 1'b0; wclk(8);
    spi_byte(8'h12, seen, oe_ok);
    chk(seen == 8'hE1, "R10 first tx", seen, 8'hE1);
    wclk(1);
    chk(rx_last == 8'h12, "R10 first rx", rx_last, 8'h12);
    tx_byte = 8'h7E;  // captured on the next falling edge? no: already taken at byte end
    spi_byte(8'h34, seen, oe_ok);
    chk(seen == 8'hE1, "R10 second tx uses byte taken at first byte end", seen, 8'hE1);
    wclk(4);
    ss_n = 1'b1; wclk(6);
    chk(rx_last == 8'h34 && rx_cnt == rc0 + 2, "R10 second rx", rx_last, 8'h34);
    chk(take_cnt == tk0 + 3, "R3 take count two bytes", take_cnt - tk0, 3);

    // R8 abort mid-byte
    rc0 = rx_cnt;
    ss_n = 1'b0; wclk(8);
    for (int i = 0; i < 4; i++) begin
      mst_mosi = 1'b1; wclk(6); sck = 1'b1; wclk(6); sck = 1'b0; wclk(6);
    end
    ss_n = 1'b1; wclk(8);
    chk(rx_cnt == rc0, "R8 no strobe on abort", rx_cnt - rc0, 0);
    ss_n = 1'b0; wclk(8);
    spi_byte(8'h3C, seen, oe_ok);
    wclk(4);
    ss_n = 1'b1; wclk(6);
    chk(rx_cnt == rc0 + 1 && rx_last == 8'h3C, "R8 fresh byte after abort", rx_last, 8'h3C);

    // R7 interrupt sharing
    irq_share = 1'b1; irq = 1'b1; #1;
    chk(mosi_oe == 1 && mosi_o == 1, "R7 irq high on pin", {mosi_oe, mosi_o}, 3);
    irq = 1'b0; #1;
    chk(mosi_oe == 1 && mosi_o == 0, "R7 irq low on pin", {mosi_oe, mosi_o}, 2);
    irq = 1'b1; three_wire = 1'b1; dir = 1'b0; ss_n = 1'b0; #1;
    chk(mosi_oe == 0, "R7 irq not on pin while selected", mosi_oe, 0);
    dir = 1'b1; tx_byte = 8'h00; wclk(8);
    chk(mosi_oe == 1 && mosi_o == 0, "R7 selected pin carries tx not irq", {mosi_oe, mosi_o}, 2);
    ss_n = 1'b1; irq_share = 1'b0; #1;
    chk(mosi_oe == 0, "R7 released when share off", mosi_oe, 0);
    wclk(4);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule